// File: doc/BRIEF.md
# Condition-Field Predicate Mask Builder

This unit converts a run of consecutive 4-bit condition fields into a packed predicate vector written to an integer result register. A start pulse supplies an 8-bit immediate, a mode select, the index of the first condition field and a vector length. The unit then reads one condition field per clock and reduces it to a single bit. It places that bit at the element's position in an accumulator. When the last element is done, it writes the packed value back once.

Each condition field carries four flags. Bit 3 is less-than, bit 2 is equal, bit 1 is greater-than and bit 0 is unordered. In select mode the low four immediate bits act as a per-flag enable, and the element bit is the OR of the enabled flags. In mask-compare mode, immediate bits [7:4] form a mask and bits [3:0] an expected pattern. The element bit is 1 when the field and the pattern agree on every masked position. Field addresses start at the given index, rise by one per element and wrap modulo the number of fields.

Top module: `cfpred_builder`

## Requirements
- R1: After reset, busy_o, done_o and wb_en_o are 0 and wb_data_o is 0.
- R2: With mode_i = 0 (select), the element bit is the OR over k of (imm_i[k] AND field[k]). Field bit 3 is lt, bit 2 is eq, bit 1 is gt and bit 0 is unordered.
- R3: In select mode, for integer compare results (exactly one of lt/eq/gt set, unordered 0), the element bit equals imm_i[3], imm_i[2] or imm_i[1] for lt, eq or gt respectively.
- R4: With mode_i = 1 (mask-compare), the element bit is 1 exactly when ((field XOR imm_i[3:0]) AND imm_i[7:4]) is 0.
- R5: In mask-compare mode, a mask imm_i[7:4] of 0 makes every element bit 1, whatever the field contents.
- R6: Element i of the vector lands in wb_data_o bit i, and every result bit at or above the vector length is 0.
- R7: After an accepted start, busy_o is high for exactly the effective vector length in cycles, with cf_rd_en_o high. In cycle i, cf_idx_o is (start index + i) mod 64.
- R8: A start pulse arriving while busy_o is high is ignored: the run in progress keeps its length, addresses and result.
- R9: done_o is high for exactly one cycle, in the cycle right after the last busy cycle. wb_en_o is high in that same cycle, with wb_data_o carrying the final vector.
- R10: mode_i, imm_i, base_idx_i and vl_i are sampled only on an accepted start. Changing them during a run has no effect on that run.
- R11: vl_i values from 1 to 64 run that many elements. A vl_i of 0, or one above 64, runs 64 elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| mode_i | input | 1 | 0 = select, 1 = mask-compare |
| imm_i | input | 8 | Immediate: [3:0] enables or expected pattern, [7:4] mask |
| base_idx_i | input | 6 | Index of the first condition field |
| vl_i | input | 7 | Vector length |
| cf_rd_en_o | output | 1 | Condition-field read enable |
| cf_idx_o | output | 6 | Condition-field read index |
| cf_data_i | input | 4 | Condition field read data, same cycle as the index |
| busy_o | output | 1 | A vector is in progress |
| wb_en_o | output | 1 | Integer result write enable |
| wb_data_o | output | 64 | Packed predicate result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a start request that overlaps a run in progress. The same case covers operand inputs that change in mid-run. The bench drives both from inside the per-cycle observation loop. In the second busy cycle it raises start_i for one cycle with a different mode, a flipped immediate, a new base and a new length, and it leaves the changed operands in place until done_o. The checks then confirm that the length, the addresses and the result still match the original operands. Other directed runs start near field 63 to make the index wrap, and use vector lengths of 1, 64 and 0. A random mix of operands and field contents covers the rest.

// File: rtl/cfpred_pkg.sv
package cfpred_pkg;
  typedef enum logic {
    MODE_SEL  = 1'b0,
    MODE_MCMP = 1'b1
  } mode_e;
endpackage

// File: rtl/cf_reduce.sv
module cf_reduce
  import cfpred_pkg::*;
#(
  parameter int FW = 4
) (
  input  mode_e           mode_i,
  input  logic [2*FW-1:0] imm_i,
  input  logic [FW-1:0]   field_i,
  output logic            bit_o
);
  logic [FW-1:0] sel_hits;
  logic [FW-1:0] mismatch;

  assign sel_hits = field_i & imm_i[FW-1:0];
  assign mismatch = (field_i ^ imm_i[FW-1:0]) & imm_i[2*FW-1:FW];

  always_comb begin
    unique case (mode_i)
      MODE_SEL:  bit_o = |sel_hits;
      MODE_MCMP: bit_o = ~|mismatch;
      default:   bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cf_seq.sv
module cf_seq
  import cfpred_pkg::*;
#(
  parameter int NUM_FIELDS = 64,
  parameter int MAX_VL     = 64,
  parameter int IMM_W      = 8,
  localparam int IDX_W     = $clog2(NUM_FIELDS),
  localparam int CNT_W     = $clog2(MAX_VL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic [CNT_W-1:0] vl_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             last_o,
  output logic [CNT_W-1:0] elem_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [CNT_W-1:0] vl_o,
  output mode_e            mode_o,
  output logic [IMM_W-1:0] imm_o,
  output logic             done_o
);
  logic             busy_q, done_q;
  logic [CNT_W-1:0] elem_q, vl_q, eff_vl;
  logic [IDX_W-1:0] idx_q, idx_nxt;
  mode_e            mode_q;
  logic [IMM_W-1:0] imm_q;

  assign accept_o = start_i && !busy_q;
  assign eff_vl   = (vl_i == '0 || vl_i > CNT_W'(MAX_VL)) ? CNT_W'(MAX_VL) : vl_i;
  assign last_o   = busy_q && (elem_q == vl_q - CNT_W'(1));
  assign idx_nxt  = (idx_q == IDX_W'(NUM_FIELDS - 1)) ? '0 : idx_q + IDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      elem_q <= '0;
      vl_q   <= '0;
      idx_q  <= '0;
      mode_q <= MODE_SEL;
      imm_q  <= '0;
    end else begin
      done_q <= last_o;
      if (accept_o) begin
        busy_q <= 1'b1;
        elem_q <= '0;
        vl_q   <= eff_vl;
        idx_q  <= base_i;
        mode_q <= mode_e'(mode_i);
        imm_q  <= imm_i;
      end else if (busy_q) begin
        elem_q <= elem_q + CNT_W'(1);
        idx_q  <= idx_nxt;
        if (last_o) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign elem_o = elem_q;
  assign idx_o  = idx_q;
  assign vl_o   = vl_q;
  assign mode_o = mode_q;
  assign imm_o  = imm_q;
  assign done_o = done_q;

  // R7: index advances by one (mod fields) per busy cycle
  a_r7_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !last_o |=> idx_q == ($past(idx_q) == IDX_W'(NUM_FIELDS - 1) ? '0 : $past(idx_q) + IDX_W'(1)));
  // R8: a run is never cut short or restarted
  a_r8_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !last_o |=> busy_q && elem_q == $past(elem_q) + CNT_W'(1));
  // R10: operands frozen during a run
  a_r10_ops_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> $stable(imm_q) && $stable(mode_q) && $stable(vl_q));
  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/cf_accum.sv
module cf_accum #(
  parameter int XLEN   = 64,
  parameter int MAX_VL = 64,
  localparam int CNT_W = $clog2(MAX_VL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             last_i,
  input  logic [CNT_W-1:0] elem_i,
  input  logic             bit_i,
  input  logic [CNT_W-1:0] vl_i,
  output logic             wb_en_o,
  output logic [XLEN-1:0]  wb_data_o
);
  logic [XLEN-1:0] acc_q, acc_nxt, wb_q;
  logic            wb_en_q;

  for (genvar g = 0; g < XLEN; g++) begin : g_bit
    if (g < MAX_VL) begin : g_live
      assign acc_nxt[g] = (step_i && elem_i == CNT_W'(g)) ? bit_i : acc_q[g];
    end else begin : g_dead
      assign acc_nxt[g] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      wb_q    <= '0;
      wb_en_q <= 1'b0;
    end else begin
      wb_en_q <= step_i && last_i;
      if (clear_i) acc_q <= '0;
      else if (step_i) acc_q <= acc_nxt;
      if (step_i && last_i) wb_q <= acc_nxt;
    end
  end

  assign wb_en_o   = wb_en_q;
  assign wb_data_o = wb_q;

  // R6: nothing at or above the vector length
  a_r6_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_q |-> (wb_q >> vl_i) == '0);
endmodule

// File: rtl/cfpred_builder.sv
module cfpred_builder
  import cfpred_pkg::*;
#(
  parameter int NUM_FIELDS = 64,
  parameter int MAX_VL     = 64,
  parameter int XLEN       = 64,
  parameter int FW         = 4,
  localparam int IMM_W     = 2 * FW,
  localparam int IDX_W     = $clog2(NUM_FIELDS),
  localparam int CNT_W     = $clog2(MAX_VL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [IDX_W-1:0] base_idx_i,
  input  logic [CNT_W-1:0] vl_i,
  output logic             cf_rd_en_o,
  output logic [IDX_W-1:0] cf_idx_o,
  input  logic [FW-1:0]    cf_data_i,
  output logic             busy_o,
  output logic             wb_en_o,
  output logic [XLEN-1:0]  wb_data_o,
  output logic             done_o
);
  logic             accept, busy, last, elem_bit;
  logic [CNT_W-1:0] elem, vl_q;
  logic [IDX_W-1:0] idx;
  mode_e            mode_q;
  logic [IMM_W-1:0] imm_q;

  cf_seq #(.NUM_FIELDS(NUM_FIELDS), .MAX_VL(MAX_VL), .IMM_W(IMM_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .mode_i, .imm_i,
    .base_i(base_idx_i), .vl_i,
    .accept_o(accept), .busy_o(busy), .last_o(last), .elem_o(elem),
    .idx_o(idx), .vl_o(vl_q), .mode_o(mode_q), .imm_o(imm_q), .done_o(done_o)
  );

  cf_reduce #(.FW(FW)) u_red (
    .mode_i(mode_q), .imm_i(imm_q), .field_i(cf_data_i), .bit_o(elem_bit)
  );

  cf_accum #(.XLEN(XLEN), .MAX_VL(MAX_VL)) u_acc (
    .clk_i, .rst_ni, .clear_i(accept), .step_i(busy), .last_i(last),
    .elem_i(elem), .bit_i(elem_bit), .vl_i(vl_q),
    .wb_en_o(wb_en_o), .wb_data_o(wb_data_o)
  );

  assign busy_o     = busy;
  assign cf_rd_en_o = busy;
  assign cf_idx_o   = idx;

  // R9: completion and write-back coincide
  a_r9_done_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == wb_en_o);
  // R9: done follows the last busy cycle
  a_r9_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
endmodule

// File: tb/sim_cfpred_builder.sv
`timescale 1ns/1ps
module sim_cfpred_builder;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, mode = 1'b0;
  logic [7:0]  imm = '0;
  logic [5:0]  base = '0;
  logic [6:0]  vl = 7'd1;
  logic        rd_en, busy, wb_en, done;
  logic [5:0]  idx;
  logic [3:0]  cf_data;
  logic [63:0] wb_data;
  logic [3:0]  cf_mem [64];
  int          n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  assign cf_data = cf_mem[idx];

  cfpred_builder u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .imm_i(imm),
    .base_idx_i(base), .vl_i(vl), .cf_rd_en_o(rd_en), .cf_idx_o(idx),
    .cf_data_i(cf_data), .busy_o(busy), .wb_en_o(wb_en), .wb_data_o(wb_data),
    .done_o(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int eff_len(input logic [6:0] v);
    return (v == 0 || v > 64) ? 64 : int'(v);
  endfunction

  function automatic logic elem_bit(input logic m, input logic [7:0] im, input logic [3:0] f);
    if (!m) return |(f & im[3:0]);
    return ((f ^ im[3:0]) & im[7:4]) == 4'h0;
  endfunction

  function automatic logic [63:0] exp_vec(input logic m, input logic [7:0] im,
                                          input logic [5:0] b, input logic [6:0] v);
    logic [63:0] r = '0;
    for (int i = 0; i < eff_len(v); i++) r[i] = elem_bit(m, im, cf_mem[(int'(b) + i) % 64]);
    return r;
  endfunction

  task automatic run(input logic m, input logic [7:0] im, input logic [5:0] b,
                     input logic [6:0] v, input bit disturb, input string req);
    logic [63:0] exp;
    int n = 0;
    bit idx_ok = 1'b1;
    exp = exp_vec(m, im, b, v);
    @(negedge clk);
    mode = m; imm = im; base = b; vl = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && n < 200) begin
      if (idx != 6'((int'(b) + n) % 64) || !rd_en) idx_ok = 1'b0;
      if (disturb && n == 1) begin
        start = 1'b1; mode = ~m; imm = ~im; base = b + 6'd17; vl = 7'd2;
      end
      if (disturb && n == 2) start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(idx_ok, "R7 index/read-enable", 64'(idx), 64'((int'(b) + n) % 64));
    check(n == eff_len(v), "R7/R11 busy length", 64'(n), 64'(eff_len(v)));
    if (disturb) check(n == eff_len(v), "R8 restart ignored", 64'(n), 64'(eff_len(v)));
    check(done && wb_en, "R9 done with wb_en", {62'd0, done, wb_en}, 64'd3);
    check(wb_data == exp, req, wb_data, exp);
    if (disturb) check(wb_data == exp, "R10 operands sampled at start", wb_data, exp);
    check((wb_data >> eff_len(v)) == 0, "R6 upper bits zero", wb_data, exp);
    @(negedge clk);
    check(!done && !wb_en && !busy, "R9 single-cycle done", {61'd0, busy, done, wb_en}, 64'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) cf_mem[i] = 4'($urandom);
    repeat (3) @(negedge clk);
    check(!busy && !done && !wb_en && wb_data == 0, "R1 reset state",
          {wb_data[60:0], busy, done, wb_en}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !wb_en && wb_data == 0, "R1 after release",
          {wb_data[60:0], busy, done, wb_en}, 64'd0);

    // R3: integer compare one-hot outcomes lt, eq, gt
    cf_mem[10] = 4'b1000; cf_mem[11] = 4'b0100; cf_mem[12] = 4'b0010;
    run(1'b0, 8'h0A, 6'd10, 7'd3, 1'b0, "R3 integer compare select");
    check(wb_data == 64'b101, "R3 lt->a eq->b gt->c", wb_data, 64'b101);
    run(1'b0, 8'h04, 6'd10, 7'd3, 1'b0, "R3 eq only");
    // R2: select mode, unordered flag used
    cf_mem[20] = 4'b0001; cf_mem[21] = 4'b0000;
    run(1'b0, 8'h01, 6'd20, 7'd2, 1'b0, "R2 unordered select");
    check(wb_data == 64'b01, "R2 unordered bit", wb_data, 64'b01);
    // R4: mask-compare
    run(1'b1, 8'hC8, 6'd5, 7'd20, 1'b0, "R4 mask compare");
    // R5: zero mask
    run(1'b1, 8'h07, 6'd33, 7'd40, 1'b0, "R5 zero mask");
    check(wb_data == {24'd0, {40{1'b1}}}, "R5 all ones", wb_data, {24'd0, {40{1'b1}}});
    // R11: boundaries, with index wrap
    run(1'b0, 8'h0F, 6'd63, 7'd1, 1'b0, "R11 vl=1");
    run(1'b0, 8'h06, 6'd60, 7'd64, 1'b0, "R11 vl=64 wrap");
    run(1'b1, 8'h39, 6'd50, 7'd0, 1'b0, "R11 vl=0 runs 64");
    run(1'b0, 8'h03, 6'd2, 7'd100, 1'b0, "R11 vl>64 runs 64");
    // R8/R10: start and operand changes during a run
    run(1'b0, 8'h0B, 6'd58, 7'd12, 1'b1, "R8 select run disturbed");
    run(1'b1, 8'hA5, 6'd3, 7'd30, 1'b1, "R10 mcmp run disturbed");

    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < 64; i++) cf_mem[i] = 4'($urandom);
      run(1'($urandom), 8'($urandom), 6'($urandom), 7'($urandom_range(1, 64)),
          1'($urandom_range(0, 3) == 0), "R2/R4 random vector");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule